// File: doc/BRIEF.md
# Cartridge Wait-State Timing Calculator

This block decides how many bus cycles a single memory access costs. The core presents a request strobe with a 32-bit address, a size code and a hint saying whether it thinks the access follows on from the previous one. One clock later the block returns the cycle count for that access. Accesses outside cartridge space get a fixed cost that depends on the address region and on whether the access is a word. Accesses inside cartridge space get a cost built from a programmable 16-bit wait-control register.

The register holds a nonsequential wait code and a sequential wait bit for each of three cartridge windows. It also holds a wait code for the backup-RAM window, a clock-output select, a prefetch enable and a game-type flag. Software writes the register and reads it back through a simple port. Only the wait fields affect timing here. The other fields are stored and read back.

The cartridge bus is 16 bits wide, so a word access there is charged as two transfers. The core's sequential hint is overridden, and nonsequential timing is charged, in two cases. The first is when the address lies on a 128 KiB boundary. The second is when the core has spent an idle cycle in cartridge space since its last real transfer.

Top module: `wsc_timer`

## Requirements
- R1: A synchronous active-low reset clears the wait-control register to 0x0000, drops `cost_valid` and clears the idle-cycle flag.
- R2: A write stores `cfg_wdata` with bit 13 forced to 0, and `cfg_rdata` shows that value from the next cycle on. Without a write the readback holds. A request in the same cycle as a write is costed with the register value from before the write.
- R3: `cost_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R4: When address bit 27 is 0, address bits 26:24 select the region and the sequential hint is ignored. Region 2 costs 3 cycles (6 for a word). Regions 5 and 6 cost 1 cycle (2 for a word). All other regions cost 1 cycle. The size code is 0 for byte, 1 for halfword and 2 for word; code 3 is costed like a halfword.
- R5: When address bit 27 is 1, address bits 26:25 pick a window (0 to 3). The window's 2-bit nonsequential code costs 5, 4, 3 or 9 cycles for codes 0 to 3. The codes sit in register bits 3:2, 6:5 and 9:8 for windows 0 to 2, and in bits 1:0 for window 3.
- R6: The sequential cost for windows 0 and 1 is 2 cycles when their sequential bit (register bit 4 or bit 7) is 0, and 1 cycle when it is 1. For window 2 (bit 10) it is 8 or 1 cycles. Window 3's sequential cost always equals its nonsequential cost.
- R7: In cartridge space, a sequential word costs twice the sequential cost, and a nonsequential word costs the nonsequential cost plus the sequential cost. A byte or halfword costs the single-transfer cost.
- R8: A cartridge access whose address bits 16:1 are all zero is costed as nonsequential even when `req_seq` is 1.
- R9: An idle strobe whose address has bit 27 set sets a flag. While the flag is set, a cartridge access is costed as nonsequential. Any request clears the flag. An idle strobe outside cartridge space has no effect. When an idle strobe and a request fall in the same cycle, the request sees the flag as it was before that cycle, and the strobe then sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe (read or write) |
| req_addr | input | 32 | Access address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as halfword |
| req_seq | input | 1 | Core's sequential hint |
| idle_strobe | input | 1 | Core spent an idle cycle |
| idle_addr | input | 32 | Address presented during the idle cycle |
| cfg_we | input | 1 | Wait-control register write enable |
| cfg_wdata | input | 16 | Wait-control register write data |
| cfg_rdata | output | 16 | Wait-control register readback |
| cost_valid | output | 1 | Cycle count valid (one clock after a request) |
| cost_cycles | output | 5 | Cycle count of the last request |

## Verification
Two events can land on the same edge as a request: an idle strobe and a register write. Both are driven in the same cycle as a sequential cartridge request. The first request must still get the sequential cost from the register value that was in place before that edge. The access that follows must then show the effect of the strobe, which forces nonsequential timing, or of the new register value. The same request-and-strobe pairing is also tried with the strobe outside cartridge space. There the next access must stay sequential.

// File: rtl/wsc_pkg.sv
// Shared types and cost tables for the wait-state timing calculator.
// Assumes single-transfer costs fit in CYC_W bits and double-transfer in COST_W.
package wsc_pkg;

    localparam int unsigned CYC_W  = 4;
    localparam int unsigned COST_W = CYC_W + 1;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    // Nonsequential cost of a 2-bit wait code.
    function automatic logic [COST_W-1:0] nseq_cost(input logic [1:0] code);
        logic [COST_W-1:0] c;
        case (code)
            2'd0:    c = COST_W'(5);
            2'd1:    c = COST_W'(4);
            2'd2:    c = COST_W'(3);
            default: c = COST_W'(9);
        endcase
        return c;
    endfunction

    // Sequential cost of a window: window 3 mirrors its nonsequential cost.
    function automatic logic [COST_W-1:0] seq_cost(input logic [1:0] win,
                                                   input logic       sbit,
                                                   input logic [1:0] ncode);
        logic [COST_W-1:0] c;
        if (win == 2'd3)      c = nseq_cost(ncode);
        else if (sbit)        c = COST_W'(1);
        else if (win == 2'd2) c = COST_W'(8);
        else                  c = COST_W'(2);
        return c;
    endfunction

endpackage

// File: rtl/wsc_ctrl_reg.sv
// Wait-control register: stores writes (reserved bit dropped) and decodes
// the per-window wait fields. Assumes fields are evenly strided from N_BASE.
module wsc_ctrl_reg #(
    parameter int unsigned REG_W        = 16,
    parameter int unsigned NUM_PROG     = 3,
    parameter int unsigned N_BASE       = 2,
    parameter int unsigned FIELD_STRIDE = 3,
    parameter int unsigned RSVD_BIT     = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    output logic [NUM_PROG:0][1:0]   ncode,
    output logic [NUM_PROG-1:0]      sbit
);

    localparam logic [REG_W-1:0] WR_MASK = ~(REG_W'(1) << RSVD_BIT);

    logic [REG_W-1:0] reg_q;

    // Register storage with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)  reg_q <= '0;
        else if (we) reg_q <= wdata & WR_MASK;
    end

    assign rdata = reg_q;

    // Field extraction for each programmable window.
    for (genvar i = 0; i < NUM_PROG; i++) begin : g_win
        localparam int unsigned NLSB = N_BASE + FIELD_STRIDE * i;
        assign ncode[i] = reg_q[NLSB +: 2];
        assign sbit[i]  = reg_q[NLSB + 2];
    end

    // Backup-RAM window code lives in the lowest field.
    assign ncode[NUM_PROG] = reg_q[1:0];

endmodule

// File: rtl/wsc_idle_track.sv
// Remembers an idle cycle spent in cartridge space until the next transfer.
// Assumes a request and a strobe on one edge: the strobe is the later event.
module wsc_idle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic idle_strobe,
    input  logic idle_in_cart,
    output logic idle_flag
);

    // Set by cartridge idle strobe, cleared by any transfer or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                          idle_flag <= 1'b0;
        else if (idle_strobe && idle_in_cart) idle_flag <= 1'b1;
        else if (req_valid)                  idle_flag <= 1'b0;
    end

endmodule

// File: rtl/wsc_cost_calc.sv
// Combinational cost of one access from address, size, hint and wait fields.
// Assumes a 16-bit cartridge bus: words there take two transfers.
module wsc_cost_calc
    import wsc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CART_BIT   = 27,
    parameter int unsigned SEL_LSB    = 25,
    parameter int unsigned REGION_LSB = 24,
    parameter int unsigned BOUND_LSB  = 1,
    parameter int unsigned BOUND_MSB  = 16,
    parameter int unsigned NUM_PROG   = 3
) (
    input  logic [ADDR_W-1:0]       addr,
    input  acc_size_e               size,
    input  logic                    seq_hint,
    input  logic                    idle_flag,
    input  logic [NUM_PROG:0][1:0]  ncode,
    input  logic [NUM_PROG-1:0]     sbit,
    output logic [COST_W-1:0]       cost
);

    logic [1:0]          win;
    logic [2:0]          region;
    logic [NUM_PROG:0]   sbit_ext;
    logic                is_word;
    logic                on_bound;
    logic                eff_seq;
    logic [COST_W-1:0]   n_cyc;
    logic [COST_W-1:0]   s_cyc;
    logic [COST_W-1:0]   cart_cost;
    logic [COST_W-1:0]   sys_cost;
    logic                unused_addr_bits;

    assign win      = addr[SEL_LSB +: 2];
    assign region   = addr[REGION_LSB +: 3];
    assign sbit_ext = {1'b0, sbit};
    assign is_word  = (size == ACC_WORD);
    assign on_bound = (addr[BOUND_MSB:BOUND_LSB] == '0);
    assign unused_addr_bits = ^{addr[ADDR_W-1:CART_BIT+1],
                                addr[REGION_LSB-1:BOUND_MSB+1],
                                addr[BOUND_LSB-1:0]};

    // Sequential only if the hint holds and no override applies.
    always_comb begin
        eff_seq = seq_hint && !on_bound && !idle_flag;
    end

    // Cartridge cost: single or double transfer on the narrow bus.
    always_comb begin
        n_cyc = nseq_cost(ncode[win]);
        s_cyc = seq_cost(win, sbit_ext[win], ncode[win]);
        if (eff_seq) cart_cost = is_word ? (s_cyc << 1) : s_cyc;
        else         cart_cost = is_word ? (n_cyc + s_cyc) : n_cyc;
    end

    // Fixed cost outside cartridge space.
    always_comb begin
        case (region)
            3'd2:       sys_cost = is_word ? COST_W'(6) : COST_W'(3);
            3'd5, 3'd6: sys_cost = is_word ? COST_W'(2) : COST_W'(1);
            default:    sys_cost = COST_W'(1);
        endcase
    end

    // Select by address space.
    always_comb begin
        cost = addr[CART_BIT] ? cart_cost : sys_cost;
    end

endmodule

// File: rtl/wsc_timer.sv
// Top of the wait-state timing calculator: holds the wait-control register,
// tracks cartridge idle cycles and registers one cost per request.
// Assumes one request per cycle; the result appears on the following cycle.
module wsc_timer
    import wsc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned REG_W    = 16,
    parameter int unsigned CART_BIT = 27,
    parameter int unsigned NUM_PROG = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_seq,
    input  logic               idle_strobe,
    input  logic [ADDR_W-1:0]  idle_addr,
    input  logic               cfg_we,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    output logic               cost_valid,
    output logic [COST_W-1:0]  cost_cycles
);

    logic [NUM_PROG:0][1:0]  ncode;
    logic [NUM_PROG-1:0]     sbit;
    logic                    idle_flag;
    logic [COST_W-1:0]       cost_next;
    logic                    unused_idle_bits;

    assign unused_idle_bits = ^{idle_addr[ADDR_W-1:CART_BIT+1], idle_addr[CART_BIT-1:0]};

    wsc_ctrl_reg #(
        .REG_W    (REG_W),
        .NUM_PROG (NUM_PROG)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .ncode (ncode),
        .sbit  (sbit)
    );

    wsc_idle_track u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .idle_strobe  (idle_strobe),
        .idle_in_cart (idle_addr[CART_BIT]),
        .idle_flag    (idle_flag)
    );

    wsc_cost_calc #(
        .ADDR_W   (ADDR_W),
        .CART_BIT (CART_BIT),
        .NUM_PROG (NUM_PROG)
    ) u_calc (
        .addr      (req_addr),
        .size      (acc_size_e'(req_size)),
        .seq_hint  (req_seq),
        .idle_flag (idle_flag),
        .ncode     (ncode),
        .sbit      (sbit),
        .cost      (cost_next)
    );

    // Result register: valid pulses the cycle after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cost_valid  <= 1'b0;
            cost_cycles <= '0;
        end else begin
            cost_valid <= req_valid;
            if (req_valid) cost_cycles <= cost_next;
        end
    end

endmodule

// File: rtl/wsc_timer_chk.sv
// Property checker for the wait-state timing calculator, bound to the top.
module wsc_timer_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned REG_W  = 16,
    parameter int unsigned COST_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              cfg_we,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic [REG_W-1:0]  cfg_rdata,
    input logic              cost_valid,
    input logic [COST_W-1:0] cost_cycles
);

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> cost_valid); // R3
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !cost_valid); // R3
    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 16'hDFFF)); // R2
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata)); // R2
    AST_SYSTEM_COST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[27] && req_size != 2'd2)
        |=> (cost_cycles == 5'd1 || cost_cycles == 5'd3)); // R4
    AST_BOUNDARY_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[27] && req_addr[16:1] == 16'd0 && req_size != 2'd2)
        |=> (cost_cycles == 5'd3 || cost_cycles == 5'd4 ||
             cost_cycles == 5'd5 || cost_cycles == 5'd9)); // R8

endmodule

bind wsc_timer wsc_timer_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .COST_W (wsc_pkg::COST_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .cost_valid  (cost_valid),
    .cost_cycles (cost_cycles)
);

// File: tb/test_wsc_timer.sv
// Sweep bench for the wait-state timing calculator; costs modelled arithmetically.
module test_wsc_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_seq = 1'b0;
    logic        idle_strobe = 1'b0;
    logic [31:0] idle_addr = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cost_valid;
    logic [4:0]  cost_cycles;

    int checks = 0;
    int errors = 0;
    logic [15:0] model_cfg = '0;
    logic        model_flag = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    wsc_timer i_wsc_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_seq     (req_seq),
        .idle_strobe (idle_strobe),
        .idle_addr   (idle_addr),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .cost_valid  (cost_valid),
        .cost_cycles (cost_cycles)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ntab(input int code);
        return (code == 0) ? 5 : (code == 1) ? 4 : (code == 2) ? 3 : 9;
    endfunction

    function automatic int exp_cart(input logic [15:0] c, input logic [31:0] a,
                                    input logic [1:0] sz, input logic sq, input logic fl);
        int sel;
        int n;
        int s;
        sel = int'(a[26:25]);
        n = (sel == 3) ? ntab(int'(c[1:0])) : ntab(int'(c[2+3*sel +: 2]));
        if (sel == 3)            s = n;
        else if (c[4+3*sel])     s = 1;
        else                     s = (sel == 2) ? 8 : 2;
        if (sq && a[16:1] != 16'd0 && !fl) return (sz == 2'd2) ? 2 * s : s;
        return (sz == 2'd2) ? n + s : n;
    endfunction

    function automatic int exp_sys(input logic [31:0] a, input logic [1:0] sz);
        int r;
        r = int'(a[26:24]);
        if (r == 2) return (sz == 2'd2) ? 6 : 3;
        if (r == 5 || r == 6) return (sz == 2'd2) ? 2 : 1;
        return 1;
    endfunction

    // One request, optionally with an idle strobe and a register write on the same edge.
    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic sq,
                          input logic with_idle, input logic [31:0] ia,
                          input logic with_wr, input logic [15:0] wv, input string tag);
        int exp;
        exp = a[27] ? exp_cart(model_cfg, a, sz, sq, model_flag) : exp_sys(a, sz);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_seq = sq;
        idle_strobe = with_idle; idle_addr = ia;
        cfg_we = with_wr; cfg_wdata = wv;
        @(negedge clk);
        req_valid = 1'b0; idle_strobe = 1'b0; cfg_we = 1'b0;
        chk(cost_valid === 1'b1, "R3", int'(cost_valid), 1);
        chk(int'(cost_cycles) == exp, tag, int'(cost_cycles), exp);
        model_flag = with_idle && ia[27];
        if (with_wr) model_cfg = wv & 16'hDFFF;
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg = v & 16'hDFFF;
        chk(cfg_rdata == model_cfg, "R2 readback", int'(cfg_rdata), int'(model_cfg));
    endtask

    task automatic idle_pulse(input logic [31:0] ia);
        idle_strobe = 1'b1; idle_addr = ia;
        @(negedge clk);
        idle_strobe = 1'b0;
        if (ia[27]) model_flag = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 16'h0000, "R1 register", int'(cfg_rdata), 0);
        chk(cost_valid == 1'b0, "R1 valid", int'(cost_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 16'h0000, "R1 after release", int'(cfg_rdata), 0);

        // R2: all ones, bit 13 must read 0; then hold without write.
        write_cfg(16'hFFFF);
        @(negedge clk);
        chk(cfg_rdata == 16'hDFFF, "R2 hold", int'(cfg_rdata), 16'hDFFF);

        // R4: every system region, every size, sequential hint set, high bits noise.
        for (int r = 0; r < 8; r++) begin
            for (int sz = 0; sz < 4; sz++) begin
                a = 32'hF000_1234 | (32'(r) << 24);
                access(a, 2'(sz), 1'b1, 1'b0, '0, 1'b0, '0, "R4 system cost");
            end
        end
        @(negedge clk);
        chk(cost_valid == 1'b0, "R3 idle bus", int'(cost_valid), 0);

        // R5 R6 R7 R8: register patterns x windows x sizes x hint x boundary.
        for (int k = 0; k < 16; k++) begin
            write_cfg(16'(k * 16'h1357 + 16'h0246));
            for (int w = 0; w < 4; w++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int sq = 0; sq < 2; sq++) begin
                        for (int b = 0; b < 2; b++) begin
                            a = 32'h0800_0000 | (32'(w) << 25) |
                                ((b == 1) ? 32'h0006_0000 : 32'h0001_2344);
                            access(a, 2'(sz), 1'(sq), 1'b0, '0, 1'b0, '0,
                                   "R5 R6 R7 R8 cartridge cost");
                        end
                    end
                end
            end
        end

        // R9: idle in cartridge forces nonsequential, then clears.
        write_cfg(16'h0491);
        a = 32'h0A00_2000;
        idle_pulse(32'h0800_0010);
        access(a, 2'd1, 1'b1, 1'b0, '0, 1'b0, '0, "R9 idle forces nonseq");
        access(a, 2'd1, 1'b1, 1'b0, '0, 1'b0, '0, "R9 flag cleared");
        idle_pulse(32'h0300_0010);
        access(a, 2'd2, 1'b1, 1'b0, '0, 1'b0, '0, "R9 idle outside ignored");
        // R9: strobe and request together, request sees old flag.
        access(a, 2'd1, 1'b1, 1'b1, 32'h0C00_0000, 1'b0, '0, "R9 same-cycle request");
        access(a, 2'd1, 1'b1, 1'b0, '0, 1'b0, '0, "R9 same-cycle strobe takes");
        access(a, 2'd1, 1'b1, 1'b1, 32'h0400_0000, 1'b0, '0, "R9 same-cycle outside");
        access(a, 2'd1, 1'b1, 1'b0, '0, 1'b0, '0, "R9 outside strobe ignored");
        // R2: write with request on one edge: request uses old register.
        access(a, 2'd2, 1'b1, 1'b0, '0, 1'b1, 16'h0000, "R2 same-cycle write");
        access(a, 2'd2, 1'b1, 1'b0, '0, 1'b0, '0, "R2 new value applies");

        // R1: reset clears register and idle flag.
        write_cfg(16'h2FFF);
        idle_pulse(32'h0800_0100);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_cfg = '0;
        model_flag = 1'b0;
        chk(cfg_rdata == 16'h0000, "R1 reset again", int'(cfg_rdata), 0);
        chk(cost_valid == 1'b0, "R1 valid cleared", int'(cost_valid), 0);
        access(32'h0800_0100, 2'd0, 1'b1, 1'b0, '0, 1'b0, '0, "R1 flag cleared");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule